// File: doc/BRIEF.md
# Complementary PWM Timer with Deadband

This block is a reload timer that drives a pulse-width-modulated signal together with its complement. A power-of-two prescaler divides the system clock into count ticks. A counter runs from 1 up to a programmed reload value. The output pair swaps at two points in each period: once when the count reaches a programmed compare value, and again when the counter reloads. A programmable deadband holds back only the low-to-high edge of each output. Because the falling edge is never delayed, the two outputs are never high together.

While the enable input is low, the outputs rest at idle levels chosen by a polarity input, and the prescaler is held clear. A polarity change made during a run takes effect only at the next compare or reload event. A one-clock reload pulse marks the end of each period.

The control path is a three-state machine (`cpwm_phase_fsm`):

- States: `PH_IDLE` (disabled), `PH_LEAD` (the part of the period before the compare match) and `PH_TRAIL` (the part after it).
- Transitions:
  - `go` (`PH_IDLE` to `PH_LEAD`) when enable rises.
  - `match` (`PH_LEAD` to `PH_TRAIL`) on a compare event.
  - `wrap` (`PH_TRAIL` to `PH_LEAD`) on a reload event.
  - `rewrap` (`PH_LEAD` back to `PH_LEAD`) on a reload that arrives with no match in the period.
  - `stop` (any state to `PH_IDLE`) when enable is low.

Top module: `cpwm_timer`

## Requirements
- R1: With enable low, the main output settles to the polarity value and the complement to its inverse within 12 clocks, whatever the deadband setting.
- R2: With polarity 0 and enable high, a period of R count ticks with compare value C (0 < C < R) keeps the main output high for (R-C)·P - D clocks and the complement high for C·P - D clocks. Here P is the prescale ratio and D is the deadband setting.
- R3: With polarity 1, the roles swap: the main output is high for C·P - D clocks per period and the complement for (R-C)·P - D clocks.
- R4: The deadband delays only the rising edge of each output, by D system clocks (D from 0 to 7, where 0 means no delay). Falling edges follow one clock after the event, and the two outputs are never both high.
- R5: The prescale select S gives P = 2^S, for S from 0 to 7. A full period lasts R·P clocks.
- R6: Clearing enable clears the prescaler. After enable is set, the first reload pulse appears exactly R·P clocks later, even if a previous run was cut off mid-count.
- R7: A polarity change while running leaves both outputs unchanged until the next compare or reload event. After the next reload, the main output shows the new polarity's reload level.
- R8: The counter starts at 1 on enable and advances once per tick. On the tick where the count equals the reload value, it returns to 1 and the reload output is high for exactly one clock.
- R9: When the compare value equals the reload value, the reload action wins, so the main output (polarity 0) stays low for the whole period.
- R10: During reset, the main output is low, the complement is high and the reload output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Timer run enable |
| pol | input | 1 | Output polarity select |
| psel | input | 3 | Prescale select, ratio 2^psel |
| reload_val | input | 16 | Count at which the period ends |
| cmp_val | input | 16 | Count at which the outputs swap mid-period |
| db_sel | input | 3 | Deadband on rising edges, in clocks |
| out_p | output | 1 | Main PWM output |
| out_n | output | 1 | Complementary PWM output |
| reload_pulse | output | 1 | One-clock pulse at each reload |

## Verification
An event is decided on the clock edge that ends the tick in which the count matches. The reload pulse is visible right after that edge. A falling output follows one clock later, and a rising output follows one clock plus D clocks later. A period therefore measured from one reload pulse to the next shows exactly (R-C)·P - D high samples on one output and C·P - D on the other.

The monitor samples on the falling clock edge. It skips the first, partial period after enable and then compares whole windows against the queue the driver filled. The first-pulse test counts falling edges from the one on which enable was raised, so the reload pulse is due on the R·P-th of them. Idle checks wait 12 clocks, which exceeds the longest deadband plus the two register stages.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRAIL = 2'd2
    } phase_e;

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick,
    output logic [(1<<PSEL_W)-2:0] pre_cnt
);
    localparam int PRE_W = (1 << PSEL_W) - 1;

    logic [PRE_W-1:0] limit;

    // limit = 2^psel - 1, built as a run of low-order ones
    always_comb begin
        limit = '0;
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(psel));
        end
    end

    assign tick = en && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!en) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             reload_evt,
    output logic             cmp_evt,
    output logic             reload_pulse
);
    localparam logic [CNT_W-1:0] START = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // reload takes priority over compare when both values match
    assign reload_evt = en && tick && (cnt >= reload_val);
    assign cmp_evt    = en && tick && (cnt == cmp_val) && !reload_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt          <= START;
            reload_pulse <= 1'b0;
        end else begin
            reload_pulse <= reload_evt;
            if (!en) begin
                cnt <= START;
            end else if (reload_evt) begin
                cnt <= START;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpwm_phase_fsm.sv
module cpwm_phase_fsm
    import cpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pol,
    input  logic cmp_evt,
    input  logic reload_evt,
    output logic raw_p,
    output logic raw_n
);
    phase_e state, state_nx;
    logic   pol_q;
    logic   pol_load;

    // next-state: go / match / wrap / rewrap / stop
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:  if (en) state_nx = PH_LEAD;
            PH_LEAD:  begin
                if (!en)          state_nx = PH_IDLE;
                else if (cmp_evt) state_nx = PH_TRAIL;
            end
            PH_TRAIL: begin
                if (!en)             state_nx = PH_IDLE;
                else if (reload_evt) state_nx = PH_LEAD;
            end
            default:  state_nx = PH_IDLE;
        endcase
    end

    // polarity is sampled only while idle or on an event
    assign pol_load = (state == PH_IDLE) || cmp_evt || reload_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            pol_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (pol_load) pol_q <= pol;
        end
    end

    always_comb begin
        unique case (state)
            PH_TRAIL: raw_p = ~pol_q;
            PH_IDLE,
            PH_LEAD:  raw_p = pol_q;
            default:  raw_p = pol_q;
        endcase
        raw_n = ~raw_p;
    end

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int   DB_W    = 3,
    parameter logic RST_VAL = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DB_W-1:0] db_sel,
    output logic            dout
);
    logic [DB_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= RST_VAL;
            wait_cnt <= '0;
        end else if (!raw) begin
            dout     <= 1'b0;          // falls undelayed, cancels a pending rise
            wait_cnt <= '0;
        end else if (!dout) begin
            if (wait_cnt == db_sel) dout <= 1'b1;
            else                    wait_cnt <= wait_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = 3,
    parameter int DB_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pol,
    input  logic [PSEL_W-1:0] psel,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [DB_W-1:0]   db_sel,
    output logic              out_p,
    output logic              out_n,
    output logic              reload_pulse
);
    localparam int PRE_W = (1 << PSEL_W) - 1;

    logic             tick;
    logic [PRE_W-1:0] pre_cnt;
    logic             reload_evt;
    logic             cmp_evt;
    logic             raw_p;
    logic             raw_n;
    logic [1:0]       raw_vec;
    logic [1:0]       out_vec;

    cpwm_prescaler #(.PSEL_W(PSEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .psel(psel),
        .tick(tick), .pre_cnt(pre_cnt)
    );

    cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .reload_val(reload_val), .cmp_val(cmp_val),
        .reload_evt(reload_evt), .cmp_evt(cmp_evt),
        .reload_pulse(reload_pulse)
    );

    cpwm_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol),
        .cmp_evt(cmp_evt), .reload_evt(reload_evt),
        .raw_p(raw_p), .raw_n(raw_n)
    );

    assign raw_vec = {raw_n, raw_p};

    for (genvar g = 0; g < 2; g++) begin : g_db
        cpwm_deadband #(.DB_W(DB_W), .RST_VAL(g == 1)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(raw_vec[g]),
            .db_sel(db_sel), .dout(out_vec[g])
        );
    end

    assign out_p = out_vec[0];
    assign out_n = out_vec[1];

endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
    parameter int PRE_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             raw_p,
    input logic [PRE_W-1:0] pre_cnt,
    input logic             out_p,
    input logic             out_n,
    input logic             reload_pulse
);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_p && out_n));

    a_r4_fall_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_p) |=> !out_p);

    a_r4_rise_after_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_p) |-> $past(raw_p));

    a_r6_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_cnt == '0));

    a_r8_pulse_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> $past(en));

endmodule

bind cpwm_timer cpwm_timer_chk #(.PRE_W((1 << PSEL_W) - 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .raw_p(raw_p), .pre_cnt(pre_cnt),
    .out_p(out_p), .out_n(out_n), .reload_pulse(reload_pulse)
);

// File: tb/cpwm_timer_tb.sv
module cpwm_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        pol = 1'b0;
    logic [2:0]  psel = '0;
    logic [15:0] reload_val = 16'd10;
    logic [15:0] cmp_val = 16'd4;
    logic [2:0]  db_sel = '0;
    logic        out_p, out_n, reload_pulse;

    always #4 clk = ~clk;   // 125 MHz

    cpwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .psel(psel),
        .reload_val(reload_val), .cmp_val(cmp_val), .db_sel(db_sel),
        .out_p(out_p), .out_n(out_n), .reload_pulse(reload_pulse)
    );

    typedef struct {
        int len;
        int hp;
        int hn;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    logic mon_on = 1'b0;
    logic done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measures each full window between reload pulses
    int  m_len = 0, m_hp = 0, m_hn = 0;
    bit  m_started = 0, m_ovl = 0;
    always @(negedge clk) begin
        if (!mon_on) begin
            m_started = 0; m_len = 0; m_hp = 0; m_hn = 0; m_ovl = 0;
        end else begin
            m_len++;
            m_hp += int'(out_p);
            m_hn += int'(out_n);
            if (out_p && out_n) m_ovl = 1;
            if (reload_pulse) begin
                if (m_started && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_len == e.len, {e.tag, " R5 R8 period"}, m_len, e.len);
                    chk(m_hp == e.hp, {e.tag, " main high time"}, m_hp, e.hp);
                    chk(m_hn == e.hn, {e.tag, " compl high time"}, m_hn, e.hn);
                    chk(!m_ovl, "R4 outputs overlap", int'(m_ovl), 0);
                end
                m_started = 1; m_len = 0; m_hp = 0; m_hn = 0; m_ovl = 0;
            end
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!reload_pulse);
    endtask

    // driver: programs a configuration and queues expected windows
    task automatic run_cfg(input int r, input int c, input int s, input int d,
                           input bit p, input string tag);
        int pp;
        pp = 1 << s;
        en = 0; mon_on = 0;
        reload_val = 16'(r); cmp_val = 16'(c); psel = 3'(s); db_sel = 3'(d); pol = p;
        wait_clk(12);
        for (int k = 0; k < 3; k++) begin
            exp_t e;
            e.len = r * pp;
            e.tag = tag;
            if (c >= r) begin
                e.hp = p ? r * pp : 0;
                e.hn = p ? 0 : r * pp;
            end else if (!p) begin
                e.hp = (r - c) * pp - d;
                e.hn = c * pp - d;
            end else begin
                e.hp = c * pp - d;
                e.hn = (r - c) * pp - d;
            end
            exp_q.push_back(e);
        end
        en = 1; mon_on = 1;
        while (exp_q.size() != 0) @(negedge clk);
        en = 0; mon_on = 0;
        wait_clk(12);
    endtask

    initial begin
        int n;
        wait_clk(3);
        chk(out_p == 0, "R10 reset main", out_p, 0);
        chk(out_n == 1, "R10 reset compl", out_n, 1);
        chk(reload_pulse == 0, "R10 reset pulse", reload_pulse, 0);
        rst_n = 1;

        db_sel = 3'd7;
        pol = 0; wait_clk(12);
        chk(out_p == 0 && out_n == 1, "R1 idle pol0", {out_p, out_n}, 1);
        pol = 1; wait_clk(12);
        chk(out_p == 1 && out_n == 0, "R1 idle pol1", {out_p, out_n}, 2);
        pol = 0; wait_clk(12);

        run_cfg(10, 4, 0, 0, 0, "R2 div1");
        run_cfg(8, 3, 1, 2, 0, "R2 R4 div2");
        run_cfg(6, 2, 3, 5, 0, "R2 R4 div8");
        run_cfg(4, 1, 7, 7, 0, "R5 div128");
        run_cfg(10, 4, 0, 1, 1, "R3 pol1");
        run_cfg(10, 10, 0, 0, 0, "R9 cmp eq reload");

        // R6: first pulse after enable, including after an aborted run
        reload_val = 16'd5; cmp_val = 16'd2; psel = 3'd2; db_sel = '0; pol = 0;
        wait_clk(12);
        en = 1; n = 0;
        do begin @(negedge clk); n++; end while (!reload_pulse && n < 100);
        chk(n == 20, "R6 R8 first pulse", n, 20);
        en = 0; wait_clk(3);
        en = 1; wait_clk(7);
        en = 0; wait_clk(3);
        en = 1; n = 0;
        do begin @(negedge clk); n++; end while (!reload_pulse && n < 100);
        chk(n == 20, "R6 first pulse after abort", n, 20);
        @(negedge clk);
        chk(reload_pulse == 0, "R8 pulse one clock", reload_pulse, 0);
        en = 0; wait_clk(12);

        // R7: polarity change mid-run is deferred
        reload_val = 16'd20; cmp_val = 16'd15; psel = '0; db_sel = '0; pol = 0;
        wait_clk(3);
        en = 1;
        wait_pulse();
        pol = 1;
        wait_clk(5);
        chk(out_p == 0, "R7 main unchanged", out_p, 0);
        chk(out_n == 1, "R7 compl unchanged", out_n, 1);
        wait_pulse();
        @(negedge clk);
        chk(out_p == 1, "R7 new pol after reload", out_p, 1);
        chk(out_n == 0, "R7 compl new pol", out_n, 0);
        en = 0; wait_clk(12);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule